// File: doc/BRIEF.md
# Block-Protocol Link Recovery Controller

This block is the terminal-side sequencing engine for a half-duplex protocol in which the two sides take turns sending blocks. A front end frames and checks each block coming back from the card. It hands this controller a one-cycle summary of the block: its kind, its sequence bit, its chaining bit, its supervisory function, the info byte and a good/bad flag. A separate timer reports when the block waiting time runs out. The controller then decides what the terminal sends next and announces it as a one-cycle launch pulse, with the block's fields held on the outputs. The options are an information block from the host, an acknowledge block, a retransmission, a supervisory answer, a resynchronisation request, or a request to reset the card.

Recovery escalates in three steps. First the last block is retransmitted or the expected block is requested again. Next a resynchronisation request is sent. Last, the card is reset. Each step allows two further attempts after the first failure. Until the first error-free block of a session arrives, the resynchronisation step is skipped. The controller holds the single pair of send and receive sequence bits. They are shared by every logical channel, and each bit toggles on its own event.

States: `ST_IDLE` (no session), `ST_READY` (terminal's turn, waiting for the host), `ST_WAIT` (block sent, waiting for a reply or a timeout). Transitions: IDLE→WAIT on session start; READY→WAIT on host send; WAIT→WAIT when a block is sent in reply; WAIT→READY when an exchange completes (unchained card information block, acknowledged chained block, accepted resync answer); WAIT→IDLE on card reset request.

Top module: `blk_link_ctrl`

## Requirements
- R1: In `ST_IDLE`, `start` launches an information block with sequence 0 and chaining bit `start_more`. In `ST_READY`, `app_send` launches an information block carrying the current send bit and `app_more`. Received blocks and timeouts outside `ST_WAIT` cause nothing.
- R2: If the terminal's last block was an information block, a timeout or a bad block makes it send an acknowledge block whose sequence equals the receive bit. At session start this is acknowledge 0.
- R3: If the last block was an acknowledge block, a timeout or a bad block makes it send that same acknowledge block again.
- R4: If the last block was a supervisory request, a timeout, a bad block, or any good block other than the matching supervisory response makes it send the same request again.
- R5: If the last block was a supervisory response, a timeout or a bad block makes it send an acknowledge block whose sequence equals the receive bit.
- R6: A good card supervisory request with function waiting-time (3), size (1) or abort (2) is answered with the response of the same function and the same info byte. Only the waiting-time answer also pulses `wtx_load`.
- R7: A good card information block whose sequence equals the receive bit toggles the receive bit. If a terminal information block is outstanding, it also toggles the send bit. With the chaining bit set, the terminal replies with an acknowledge block carrying the new receive bit. Without it, the controller enters `ST_READY`.
- R8: While a terminal information block is outstanding, a good card acknowledge block whose sequence differs from the send bit toggles the send bit and enters `ST_READY`. If its sequence equals the send bit, the terminal sends the information block again.
- R9: After an error-free block has been received in the session, a third consecutive failure sends a resynchronisation request (supervisory, function 0).
- R10: Before any error-free block has been received in the session, a third consecutive failure pulses `card_reset` and enters `ST_IDLE`.
- R11: A matching resynchronisation response clears both sequence bits and the retry state, then enters `ST_READY`. A third failure of the resynchronisation request pulses `card_reset`.
- R12: When `rx_done` and `bwt_timeout` arrive in the same cycle, the received block alone decides the outcome.
- R13: `tx_go` and `card_reset` are one-cycle pulses, never high together, registered one cycle after the causing input. Kind codes are information 0, acknowledge 1, supervisory 2. Non-supervisory blocks drive function and info 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Open a session with the first information block |
| start_more | input | 1 | Chaining bit of the first block |
| app_send | input | 1 | Host hands over the next information block |
| app_more | input | 1 | Chaining bit of that block |
| rx_done | input | 1 | A received block has been decoded |
| rx_ok | input | 1 | The received block is error-free |
| rx_kind | input | 2 | Kind of received block |
| rx_seq | input | 1 | Sequence bit of received block |
| rx_more | input | 1 | Chaining bit of received block |
| rx_resp | input | 1 | Supervisory block is a response |
| rx_func | input | 2 | Supervisory function |
| rx_inf | input | 8 | Supervisory info byte |
| bwt_timeout | input | 1 | Block waiting time expired |
| tx_go | output | 1 | Launch the block on the tx fields |
| tx_kind | output | 2 | Kind of block to send |
| tx_seq | output | 1 | Sequence bit to send |
| tx_more | output | 1 | Chaining bit to send |
| tx_resp | output | 1 | Supervisory response flag |
| tx_func | output | 2 | Supervisory function |
| tx_inf | output | 8 | Supervisory info byte |
| wtx_load | output | 1 | Extended waiting time starts from this response |
| card_reset | output | 1 | Request card reset or deactivation |

## Verification
A block report and a waiting-time timeout can land in the same cycle. The bench drives both together twice. In one case the block is a good information block, and the controller must stay silent and advance its sequence bits. In the other case the block is bad, and exactly one acknowledge block must come out, not two. The scoreboard rejects any extra launch, and the next host block's sequence bit shows whether the good block was taken.

// File: rtl/blk_pkg.sv
package blk_pkg;
    localparam int INF_W = 8;

    typedef enum logic [1:0] {BK_I = 2'd0, BK_R = 2'd1, BK_S = 2'd2} bkind_e;
    typedef enum logic [1:0] {SF_RESYNC = 2'd0, SF_IFS = 2'd1, SF_ABORT = 2'd2, SF_WTX = 2'd3} sfunc_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READY = 2'd1, ST_WAIT = 2'd2} lstate_e;

    typedef struct packed {
        logic [1:0]       kind;
        logic             seq;
        logic             more;
        logic             resp;
        logic [1:0]       func;
        logic [INF_W-1:0] inf;
    } blk_t;
endpackage

// File: rtl/blk_seq_bits.sv
module blk_seq_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tog_ns,
    input  logic tog_nr,
    output logic ns,
    output logic nr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns <= 1'b0;
            nr <= 1'b0;
        end else if (clr) begin
            ns <= 1'b0;
            nr <= 1'b0;
        end else begin
            if (tog_ns) ns <= ~ns;
            if (tog_nr) nr <= ~nr;
        end
    end
endmodule

// File: rtl/blk_retry.sv
module blk_retry #(
    parameter int MAX_RETRY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    input  logic go_resync,
    output logic exhausted,
    output logic resync_lvl
);
    localparam int CNT_W = $clog2(MAX_RETRY + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            resync_lvl <= 1'b0;
        end else if (go_resync) begin
            cnt        <= '0;
            resync_lvl <= 1'b1;
        end else if (clr) begin
            cnt        <= '0;
            resync_lvl <= 1'b0;
        end else if (bump && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign exhausted = (cnt == LIMIT);
endmodule

// File: rtl/blk_link_ctrl.sv
module blk_link_ctrl
    import blk_pkg::*;
#(
    parameter int MAX_RETRY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_more,
    input  logic             app_send,
    input  logic             app_more,
    input  logic             rx_done,
    input  logic             rx_ok,
    input  logic [1:0]       rx_kind,
    input  logic             rx_seq,
    input  logic             rx_more,
    input  logic             rx_resp,
    input  logic [1:0]       rx_func,
    input  logic [INF_W-1:0] rx_inf,
    input  logic             bwt_timeout,
    output logic             tx_go,
    output logic [1:0]       tx_kind,
    output logic             tx_seq,
    output logic             tx_more,
    output logic             tx_resp,
    output logic [1:0]       tx_func,
    output logic [INF_W-1:0] tx_inf,
    output logic             wtx_load,
    output logic             card_reset
);
    lstate_e state_q, n_state;
    blk_t    last_q, n_last;
    logic    go_q, n_go, wtx_q, n_wtx, rst_q, n_rst;
    logic    iout_q, n_iout, first_q, n_first;
    logic    sq_clr, tog_ns, tog_nr, rt_clr, rt_bump, rt_res, fail;
    logic    ns, nr, exhausted, resync_lvl;

    blk_seq_bits u_seq (
        .clk(clk), .rst_n(rst_n), .clr(sq_clr),
        .tog_ns(tog_ns), .tog_nr(tog_nr), .ns(ns), .nr(nr)
    );

    blk_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(rt_clr), .bump(rt_bump),
        .go_resync(rt_res), .exhausted(exhausted), .resync_lvl(resync_lvl)
    );

    function automatic blk_t mk_blk(logic [1:0] k, logic s, logic m, logic r,
                                    logic [1:0] f, logic [INF_W-1:0] i);
        blk_t b;
        b.kind = k; b.seq = s; b.more = m; b.resp = r; b.func = f; b.inf = i;
        return b;
    endfunction

    // state and launch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            last_q  <= '0;
            go_q    <= 1'b0;
            wtx_q   <= 1'b0;
            rst_q   <= 1'b0;
            iout_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            state_q <= n_state;
            last_q  <= n_last;
            go_q    <= n_go;
            wtx_q   <= n_wtx;
            rst_q   <= n_rst;
            iout_q  <= n_iout;
            first_q <= n_first;
        end
    end

    // next-block decision
    always_comb begin
        n_state = state_q;
        n_last  = last_q;
        n_go    = 1'b0;
        n_wtx   = 1'b0;
        n_rst   = 1'b0;
        n_iout  = iout_q;
        n_first = first_q;
        sq_clr  = 1'b0;
        tog_ns  = 1'b0;
        tog_nr  = 1'b0;
        rt_clr  = 1'b0;
        rt_bump = 1'b0;
        rt_res  = 1'b0;
        fail    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    sq_clr  = 1'b1;
                    rt_clr  = 1'b1;
                    n_first = 1'b1;
                    n_iout  = 1'b1;
                    n_last  = mk_blk(BK_I, 1'b0, start_more, 1'b0, SF_RESYNC, '0);
                    n_go    = 1'b1;
                    n_state = ST_WAIT;
                end
            end
            ST_READY: begin
                if (app_send) begin
                    n_iout  = 1'b1;
                    n_last  = mk_blk(BK_I, ns, app_more, 1'b0, SF_RESYNC, '0);
                    n_go    = 1'b1;
                    n_state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rx_done || bwt_timeout) begin
                    fail = 1'b1;
                    if (rx_done && rx_ok) begin
                        if (last_q.kind == BK_S && !last_q.resp) begin
                            if (rx_kind == BK_S && rx_resp && rx_func == last_q.func) begin
                                fail    = 1'b0;
                                sq_clr  = 1'b1;
                                rt_clr  = 1'b1;
                                n_iout  = 1'b0;
                                n_first = 1'b0;
                                n_state = ST_READY;
                            end
                        end else begin
                            case (rx_kind)
                                BK_I: begin
                                    if (rx_seq == nr) begin
                                        fail    = 1'b0;
                                        tog_nr  = 1'b1;
                                        rt_clr  = 1'b1;
                                        n_first = 1'b0;
                                        if (iout_q) begin
                                            tog_ns = 1'b1;
                                            n_iout = 1'b0;
                                        end
                                        if (rx_more) begin
                                            n_last = mk_blk(BK_R, ~nr, 1'b0, 1'b0, SF_RESYNC, '0);
                                            n_go   = 1'b1;
                                        end else begin
                                            n_state = ST_READY;
                                        end
                                    end
                                end
                                BK_R: begin
                                    if (iout_q && rx_seq != ns) begin
                                        fail    = 1'b0;
                                        tog_ns  = 1'b1;
                                        n_iout  = 1'b0;
                                        rt_clr  = 1'b1;
                                        n_first = 1'b0;
                                        n_state = ST_READY;
                                    end else if (iout_q && last_q.kind == BK_I && !exhausted) begin
                                        fail    = 1'b0;
                                        rt_bump = 1'b1;
                                        n_first = 1'b0;
                                        n_go    = 1'b1;
                                    end
                                end
                                BK_S: begin
                                    if (!rx_resp && rx_func != SF_RESYNC) begin
                                        fail    = 1'b0;
                                        rt_clr  = 1'b1;
                                        n_first = 1'b0;
                                        n_last  = mk_blk(BK_S, 1'b0, 1'b0, 1'b1, rx_func, rx_inf);
                                        n_go    = 1'b1;
                                        n_wtx   = (rx_func == SF_WTX);
                                        if (rx_func == SF_ABORT) n_iout = 1'b0;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                    if (fail) begin
                        if (exhausted) begin
                            if (first_q || resync_lvl) begin
                                n_rst   = 1'b1;
                                n_iout  = 1'b0;
                                n_state = ST_IDLE;
                            end else begin
                                rt_res = 1'b1;
                                n_last = mk_blk(BK_S, 1'b0, 1'b0, 1'b0, SF_RESYNC, '0);
                                n_go   = 1'b1;
                            end
                        end else begin
                            rt_bump = 1'b1;
                            n_go    = 1'b1;
                            if (last_q.kind == BK_I || (last_q.kind == BK_S && last_q.resp))
                                n_last = mk_blk(BK_R, nr, 1'b0, 1'b0, SF_RESYNC, '0);
                        end
                    end
                end
            end
            default: n_state = ST_IDLE;
        endcase
    end

    assign tx_go      = go_q;
    assign tx_kind    = last_q.kind;
    assign tx_seq     = last_q.seq;
    assign tx_more    = last_q.more;
    assign tx_resp    = last_q.resp;
    assign tx_func    = last_q.func;
    assign tx_inf     = last_q.inf;
    assign wtx_load   = wtx_q;
    assign card_reset = rst_q;
endmodule

// File: rtl/blk_link_chk.sv
module blk_link_chk
    import blk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       app_send,
    input logic       rx_done,
    input logic       bwt_timeout,
    input logic       tx_go,
    input logic [1:0] tx_kind,
    input logic       tx_seq,
    input logic       tx_resp,
    input logic [1:0] tx_func,
    input logic       wtx_load,
    input logic       card_reset,
    input lstate_e    state_q
);
    assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_go && card_reset));

    assert_start_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |=> (tx_go && tx_kind == 2'd0 && tx_seq == 1'b0));

    assert_quiet_outside_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT && !start && !app_send) |=> (!tx_go && !card_reset));

    assert_launch_has_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_go) |-> $past(start || app_send || rx_done || bwt_timeout));

    assert_wtx_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wtx_load |-> (tx_go && tx_kind == 2'd2 && tx_resp && tx_func == 2'd3));

    assert_reset_goes_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        card_reset |=> (!tx_go && !card_reset && state_q == ST_IDLE));
endmodule

bind blk_link_ctrl blk_link_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .app_send(app_send),
    .rx_done(rx_done), .bwt_timeout(bwt_timeout), .tx_go(tx_go),
    .tx_kind(tx_kind), .tx_seq(tx_seq), .tx_resp(tx_resp), .tx_func(tx_func),
    .wtx_load(wtx_load), .card_reset(card_reset), .state_q(state_q)
);

// File: tb/blk_link_ctrl_tb.sv
module blk_link_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, start_more = 0, app_send = 0, app_more = 0;
    logic rx_done = 0, rx_ok = 0, rx_seq = 0, rx_more = 0, rx_resp = 0, bwt_timeout = 0;
    logic [1:0] rx_kind = 0, rx_func = 0;
    logic [7:0] rx_inf = 0;
    logic tx_go, tx_seq, tx_more, tx_resp, wtx_load, card_reset;
    logic [1:0] tx_kind, tx_func;
    logic [7:0] tx_inf;

    int vectors = 0, errors = 0, cycles = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    blk_link_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_more(start_more),
        .app_send(app_send), .app_more(app_more), .rx_done(rx_done), .rx_ok(rx_ok),
        .rx_kind(rx_kind), .rx_seq(rx_seq), .rx_more(rx_more), .rx_resp(rx_resp),
        .rx_func(rx_func), .rx_inf(rx_inf), .bwt_timeout(bwt_timeout),
        .tx_go(tx_go), .tx_kind(tx_kind), .tx_seq(tx_seq), .tx_more(tx_more),
        .tx_resp(tx_resp), .tx_func(tx_func), .tx_inf(tx_inf),
        .wtx_load(wtx_load), .card_reset(card_reset)
    );

    // item: {reset, wtx, kind[1:0], seq, more, resp, func[1:0], inf[7:0]}
    task automatic expect_blk(input logic [1:0] k, input logic s, input logic m,
                              input logic r, input logic [1:0] f, input logic [7:0] i,
                              input logic w, input string tag);
        exp_q.push_back({1'b0, w, k, s, m, r, f, i});
        tag_q.push_back(tag);
    endtask

    task automatic expect_rst(input string tag);
        exp_q.push_back({1'b1, 16'h0});
        tag_q.push_back(tag);
    endtask

    // monitor: compares every launch or reset against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (tx_go || card_reset)) begin
            logic [16:0] act;
            act = {card_reset, wtx_load, tx_kind, tx_seq, tx_more, tx_resp, tx_func, tx_inf};
            vectors++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected launch (R1/R12) actual=%h expected=none", act);
            end else begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[16] ? (!card_reset || tx_go) : (act != e)) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic quiet(input string tag);
        vectors++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s actual=%0d pending expected=0 pending", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic do_start(input logic m);
        @(negedge clk); start = 1; start_more = m;
        @(negedge clk); start = 0; start_more = 0;
        settle();
    endtask

    task automatic do_app(input logic m);
        @(negedge clk); app_send = 1; app_more = m;
        @(negedge clk); app_send = 0; app_more = 0;
        settle();
    endtask

    task automatic card(input logic ok, input logic [1:0] k, input logic s, input logic m,
                        input logic r, input logic [1:0] f, input logic [7:0] i, input logic tmo);
        @(negedge clk);
        rx_done = 1; rx_ok = ok; rx_kind = k; rx_seq = s; rx_more = m;
        rx_resp = r; rx_func = f; rx_inf = i; bwt_timeout = tmo;
        @(negedge clk);
        rx_done = 0; rx_ok = 0; rx_kind = 0; rx_seq = 0; rx_more = 0;
        rx_resp = 0; rx_func = 0; rx_inf = 0; bwt_timeout = 0;
        settle();
    endtask

    task automatic tmo();
        @(negedge clk); bwt_timeout = 1;
        @(negedge clk); bwt_timeout = 0;
        settle();
    endtask

    initial begin : watchdog
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d cycles expected<20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        vectors++;
        if (tx_go || card_reset) begin
            errors++;
            $display("FAIL R13 reset state actual=%b%b expected=00", tx_go, card_reset);
        end
        rst_n = 1;
        settle();

        // session start that never succeeds: R2 then R3 then R10
        expect_blk(0, 0, 0, 0, 0, 0, 0, "R1 first block I(0)");
        do_start(0);
        expect_blk(1, 0, 0, 0, 0, 0, 0, "R2 first-block timeout gives R(0)");
        tmo();
        expect_blk(1, 0, 0, 0, 0, 0, 0, "R3 R-block resent after bad block");
        card(0, 0, 0, 0, 0, 0, 0, 0);
        expect_rst("R10 third failure at start resets card");
        tmo();
        quiet("R10 reset drained");

        // new session, normal exchange and chaining (R7, R8)
        expect_blk(0, 0, 0, 0, 0, 0, 0, "R1 restart I(0)");
        do_start(0);
        card(1, 0, 0, 0, 0, 0, 0, 0);
        quiet("R7 unchained card I ends exchange");
        expect_blk(0, 1, 1, 0, 0, 0, 0, "R1 chained I carries send bit 1");
        do_app(1);
        card(1, 1, 0, 0, 0, 0, 0, 0);
        quiet("R8 R(0) acknowledges chained I(1)");
        expect_blk(0, 0, 0, 0, 0, 0, 0, "R8 send bit toggled to 0");
        do_app(0);
        expect_blk(1, 0, 0, 0, 0, 0, 0, "R7 chained card I answered with R(0)");
        card(1, 0, 1, 1, 0, 0, 0, 0);
        card(1, 0, 0, 0, 0, 0, 0, 0);
        quiet("R7 last card chain block");

        // waiting-time request then error after the response (R6, R5)
        expect_blk(0, 1, 0, 0, 0, 0, 0, "R7 send bit 1 after card chain");
        do_app(0);
        expect_blk(2, 0, 0, 1, 3, 8'h05, 1, "R6 WTX response echoes value");
        card(1, 2, 0, 0, 0, 3, 8'h05, 0);
        expect_blk(1, 1, 0, 0, 0, 0, 0, "R5 bad block after S response gives R(1)");
        card(0, 1, 0, 0, 0, 0, 0, 0);
        card(1, 0, 1, 0, 0, 0, 0, 0);
        quiet("R7 card I(1) accepted");

        // mid-session escalation to resync and reset (R9, R4, R11)
        expect_blk(0, 0, 0, 0, 0, 0, 0, "R7 send bit 0");
        do_app(0);
        expect_blk(1, 0, 0, 0, 0, 0, 0, "R2 timeout after I gives R(0)");
        tmo();
        expect_blk(1, 0, 0, 0, 0, 0, 0, "R3 R(0) repeated");
        tmo();
        expect_blk(2, 0, 0, 0, 0, 0, 0, "R9 third failure sends resync request");
        tmo();
        expect_blk(2, 0, 0, 0, 0, 0, 0, "R4 non-matching reply repeats request");
        card(1, 1, 0, 0, 0, 0, 0, 0);
        expect_blk(2, 0, 0, 0, 0, 0, 0, "R4 timeout repeats request");
        tmo();
        expect_rst("R11 failed resync resets card");
        tmo();
        quiet("R11 reset drained");

        // successful resync clears the sequence bits (R11)
        expect_blk(0, 0, 0, 0, 0, 0, 0, "R1 session three");
        do_start(0);
        card(1, 0, 0, 0, 0, 0, 0, 0);
        expect_blk(0, 1, 0, 0, 0, 0, 0, "R7 send bit 1");
        do_app(0);
        expect_blk(1, 1, 0, 0, 0, 0, 0, "R2 R(1)");
        tmo();
        expect_blk(1, 1, 0, 0, 0, 0, 0, "R3 R(1) again");
        tmo();
        expect_blk(2, 0, 0, 0, 0, 0, 0, "R9 resync request");
        tmo();
        card(1, 2, 0, 0, 1, 0, 0, 0);
        quiet("R11 resync response accepted");
        expect_blk(0, 0, 0, 0, 0, 0, 0, "R11 send bit cleared to 0");
        do_app(0);

        // same-cycle block and timeout (R12)
        card(1, 0, 0, 0, 0, 0, 0, 1);
        quiet("R12 good block wins over timeout");
        expect_blk(0, 1, 0, 0, 0, 0, 0, "R12 good block was taken, send bit 1");
        do_app(0);
        expect_blk(1, 1, 0, 0, 0, 0, 0, "R12 bad block plus timeout gives one R(1)");
        card(0, 0, 0, 0, 0, 0, 0, 1);
        card(1, 0, 1, 0, 0, 0, 0, 0);
        quiet("R12 single recovery block");

        // size request (R6)
        expect_blk(0, 0, 0, 0, 0, 0, 0, "R7 send bit 0");
        do_app(0);
        expect_blk(2, 0, 0, 1, 1, 8'h40, 0, "R6 IFS response echoes size");
        card(1, 2, 0, 0, 0, 1, 8'h40, 0);
        card(1, 0, 0, 0, 0, 0, 0, 0);

        // events while ready are ignored; card NAK resends I (R1, R8)
        tmo();
        card(1, 0, 1, 0, 0, 0, 0, 0);
        quiet("R1 events in READY ignored");
        expect_blk(0, 1, 0, 0, 0, 0, 0, "R1 send bit unchanged by ignored events");
        do_app(0);
        expect_blk(0, 1, 0, 0, 0, 0, 0, "R8 R(1) equal to send bit resends I(1)");
        card(1, 1, 1, 0, 0, 0, 0, 0);
        card(1, 0, 1, 0, 0, 0, 0, 0);
        quiet("R8 exchange closed");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule